// File: doc/BRIEF.md
# SPI Flash Memory-Mapped Read Sequencer

This block serves word reads from a memory-mapped flash window by running one command-mode read on an SPI flash. A request names a chip select, a byte address and a length of one to four bytes. The block then selects the device and sends the opcode and the address. It sends a programmable run of dummy bytes, clocks in the data bytes and returns them packed into a 32-bit response word. Each chip select has its own 32-bit control word, supplied on a flat input bus. That word gives the opcode, the command mode, the address width, the dummy count and a chip-select suppression bit.

The dummy count comes from a 3-bit value made of two separate control-word fields, and that value is multiplied by eight. Normal-read and fast-read modes both run the full sequence using whatever count is programmed. The other two mode encodings do not touch the bus and return zero at once. The serial port runs SPI mode 0 with a parameterised clock divider, and a new request can be taken only while the block is idle.

Top module: `sfl_read_seq`

## Requirements
- R1: After a synchronous active-high reset, every `spi_cs_n` line is high, `spi_sclk` is low, and `busy` and `rsp_valid` are low.
- R2: The first byte shifted out after chip select falls is the opcode in control-word bits 23:16.
- R3: With control-word bit 13 set, four address bytes follow the opcode; with it clear, three follow and only the low 24 address bits are sent. Address bytes go most significant byte first.
- R4: After the address, the block sends 8 × D bytes of 0xFF, where D is 3 bits wide: D[2] is control-word bit 14 and D[1:0] are bits 7:6. With D = 0 no dummy byte is sent.
- R5: After the dummies, `req_bytes`+1 bytes of 0x00 are sent (`req_bytes` 0..3 means 1..4 bytes). Received byte i lands in `rsp_data[8i+7:8i]` and unused upper bytes read zero.
- R6: Control-word bits 1:0 give the mode. 0 (normal read) and 1 (fast read) both run the sequence. 2 and 3 give a response with data zero within four cycles, with no chip select and no serial clock.
- R7: With control-word bit 2 set, chip select stays high for the whole request, but the serial sequence still runs.
- R8: `req_cs` picks both the control word (word k at bits 32k+31:32k of `ctrl_words`) and the one `spi_cs_n` line driven low.
- R9: While `busy` is high, requests are ignored. `rsp_valid` pulses for one cycle in the same cycle that chip select returns high. A request held in that cycle is accepted at once.
- R10: The serial clock idles low. MOSI changes only while the clock is low, and bits go out most significant first. MISO is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe, taken when idle |
| req_addr | input | ADDR_W | Flash byte address |
| req_bytes | input | 2 | Number of data bytes minus one |
| req_cs | input | CS_W | Chip select index |
| ctrl_words | input | NUM_CS*32 | Control word per chip select |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Assembled read data, first byte lowest |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The response of one read and the acceptance of the next can fall in the same cycle. The block returns to idle as it raises `rsp_valid`, and a waiting request is taken on that edge. The bench holds `req_valid` high through a whole read and moves the address partway through, to a value that must be ignored. It loads a new address in the response cycle. The bench then expects the first response to carry data for the original address and `busy` to be high one cycle later, and it checks that the second bus sequence carries the new address.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  localparam int CTRL_W = 32;

  typedef enum logic [1:0] {
    CM_READ  = 2'd0,
    CM_FAST  = 2'd1,
    CM_WRITE = 2'd2,
    CM_USER  = 2'd3
  } cmd_mode_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic       wide_addr;
    logic [2:0] dummy_units;
    logic       cs_hold_off;
    cmd_mode_e  mode;
  } flash_cfg_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_OPC,
    SQ_ADR,
    SQ_DMY,
    SQ_DAT,
    SQ_END
  } seq_state_e;
endpackage

// File: rtl/sfl_ctrl_decode.sv
module sfl_ctrl_decode
  import sfl_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int CS_W   = 1
) (
  input  logic [NUM_CS*CTRL_W-1:0] ctrl_words,
  input  logic [CS_W-1:0]          sel,
  output flash_cfg_t               cfg,
  output logic                     is_read,
  output logic [5:0]               dummy_bytes
);
  logic [CTRL_W-1:0] words [NUM_CS];
  logic [CTRL_W-1:0] w;

  genvar k;
  generate
    for (k = 0; k < NUM_CS; k++) begin : g_split
      assign words[k] = ctrl_words[k*CTRL_W +: CTRL_W];
    end
  endgenerate

  assign w = words[sel];

  always_comb begin
    cfg.opcode      = w[23:16];
    cfg.wide_addr   = w[13];
    cfg.dummy_units = {w[14], w[7:6]};
    cfg.cs_hold_off = w[2];
    cfg.mode        = cmd_mode_e'(w[1:0]);
  end

  assign is_read     = (cfg.mode == CM_READ) || (cfg.mode == CM_FAST);
  assign dummy_bytes = {cfg.dummy_units, 3'b000};

  logic unused_ctrl;
  assign unused_ctrl = ^{w[31:24], w[12:8], w[5:3]};
endmodule

// File: rtl/sfl_spi_byte.sv
module sfl_spi_byte #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             busy_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_sh;
  logic             sclk_q;
  logic             mosi_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        tx_sh  <= {tx_byte[6:0], 1'b0};
        mosi_q <= tx_byte[7];
        bit_q  <= '0;
        div_q  <= '0;
        sclk_q <= 1'b0;
      end else if (busy_q) begin
        if (div_q == DIV_LAST) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_sh  <= {rx_sh[6:0], miso};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q  <= bit_q + 3'd1;
              mosi_q <= tx_sh[7];
              tx_sh  <= {tx_sh[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign done    = done_q;
  assign rx_byte = rx_sh;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;

  p_mosi_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_q));
  p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q);
  p_sclk_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !sclk_q);
endmodule

// File: rtl/sfl_read_fsm.sv
module sfl_read_fsm
  import sfl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_CS = 2,
  parameter int CS_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_bytes,
  input  logic [CS_W-1:0]   req_cs,
  input  flash_cfg_t        cfg,
  input  logic              is_read,
  input  logic [5:0]        dummy_bytes,
  output logic              busy,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic [NUM_CS-1:0] cs_n,
  output logic              eng_start,
  output logic [7:0]        eng_tx,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx
);
  seq_state_e        state_q;
  logic [31:0]       addr_q;
  logic [1:0]        size_q;
  logic              wide_q;
  logic [5:0]        dummy_q;
  logic [5:0]        cnt_q;
  logic [31:0]       data_q;
  logic [31:0]       rsp_data_q;
  logic              rsp_valid_q;
  logic              start_q;
  logic [7:0]        tx_q;
  logic [NUM_CS-1:0] cs_n_q;
  logic [NUM_CS-1:0] sel_onehot;
  logic [31:0]       req_addr32;

  assign sel_onehot = NUM_CS'(1) << req_cs;
  assign req_addr32 = 32'(req_addr);

  function automatic logic [7:0] addr_byte(input logic [31:0] a, input logic [1:0] idx);
    return a[{idx, 3'b000} +: 8];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SQ_IDLE;
      addr_q      <= '0;
      size_q      <= '0;
      wide_q      <= 1'b0;
      dummy_q     <= '0;
      cnt_q       <= '0;
      data_q      <= '0;
      rsp_data_q  <= '0;
      rsp_valid_q <= 1'b0;
      start_q     <= 1'b0;
      tx_q        <= '0;
      cs_n_q      <= '1;
    end else begin
      start_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      case (state_q)
        SQ_IDLE: if (req_valid) begin
          addr_q  <= req_addr32;
          size_q  <= req_bytes;
          wide_q  <= cfg.wide_addr;
          dummy_q <= dummy_bytes;
          data_q  <= '0;
          if (is_read) begin
            state_q <= SQ_OPC;
            start_q <= 1'b1;
            tx_q    <= cfg.opcode;
            if (!cfg.cs_hold_off) cs_n_q <= ~sel_onehot;
          end else begin
            state_q <= SQ_END;
          end
        end
        SQ_OPC: if (eng_done) begin
          state_q <= SQ_ADR;
          cnt_q   <= wide_q ? 6'd3 : 6'd2;
          tx_q    <= addr_byte(addr_q, wide_q ? 2'd3 : 2'd2);
          start_q <= 1'b1;
        end
        SQ_ADR: if (eng_done) begin
          start_q <= 1'b1;
          if (cnt_q == 6'd0) begin
            if (dummy_q != 6'd0) begin
              state_q <= SQ_DMY;
              cnt_q   <= dummy_q - 6'd1;
              tx_q    <= 8'hFF;
            end else begin
              state_q <= SQ_DAT;
              cnt_q   <= '0;
              tx_q    <= 8'h00;
            end
          end else begin
            cnt_q <= cnt_q - 6'd1;
            tx_q  <= addr_byte(addr_q, cnt_q[1:0] - 2'd1);
          end
        end
        SQ_DMY: if (eng_done) begin
          start_q <= 1'b1;
          if (cnt_q == 6'd0) begin
            state_q <= SQ_DAT;
            tx_q    <= 8'h00;
          end else begin
            cnt_q <= cnt_q - 6'd1;
            tx_q  <= 8'hFF;
          end
        end
        SQ_DAT: if (eng_done) begin
          data_q[{cnt_q[1:0], 3'b000} +: 8] <= eng_rx;
          if (cnt_q[1:0] == size_q) begin
            state_q <= SQ_END;
          end else begin
            cnt_q   <= cnt_q + 6'd1;
            tx_q    <= 8'h00;
            start_q <= 1'b1;
          end
        end
        SQ_END: begin
          cs_n_q      <= '1;
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= data_q;
          state_q     <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != SQ_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign cs_n      = cs_n_q;
  assign eng_start = start_q;
  assign eng_tx    = tx_q;

  p_cs_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n_q));
  p_rsp_cs_high_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_q |-> (&cs_n_q));
  p_busy_holds_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != SQ_IDLE) |=> $stable(addr_q));
  p_dummy_ff_r4: assert property (@(posedge clk) disable iff (rst)
    (start_q && state_q == SQ_DMY) |-> (tx_q == 8'hFF));
endmodule

// File: rtl/sfl_read_seq.sv
module sfl_read_seq
  import sfl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_CS   = 2,
  parameter int HALF_DIV = 2,
  localparam int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               req_bytes,
  input  logic [CS_W-1:0]          req_cs,
  input  logic [NUM_CS*CTRL_W-1:0] ctrl_words,
  output logic                     busy,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_data,
  output logic [NUM_CS-1:0]        spi_cs_n,
  output logic                     spi_sclk,
  output logic                     spi_mosi,
  input  logic                     spi_miso
);
  flash_cfg_t cfg;
  logic       is_read;
  logic [5:0] dummy_bytes;
  logic       eng_start;
  logic [7:0] eng_tx;
  logic       eng_done;
  logic [7:0] eng_rx;

  sfl_ctrl_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_decode (
    .ctrl_words (ctrl_words),
    .sel        (req_cs),
    .cfg        (cfg),
    .is_read    (is_read),
    .dummy_bytes(dummy_bytes)
  );

  sfl_read_fsm #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .CS_W(CS_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_bytes  (req_bytes),
    .req_cs     (req_cs),
    .cfg        (cfg),
    .is_read    (is_read),
    .dummy_bytes(dummy_bytes),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .cs_n       (spi_cs_n),
    .eng_start  (eng_start),
    .eng_tx     (eng_tx),
    .eng_done   (eng_done),
    .eng_rx     (eng_rx)
  );

  sfl_spi_byte #(.HALF_DIV(HALF_DIV)) u_engine (
    .clk    (clk),
    .rst    (rst),
    .start  (eng_start),
    .tx_byte(eng_tx),
    .done   (eng_done),
    .rx_byte(eng_rx),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .miso   (spi_miso)
  );
endmodule

// File: tb/sfl_read_seq_tb.sv
`timescale 1ns/1ps
module sfl_read_seq_tb;
  localparam int NUM_CS = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_bytes = '0;
  logic [0:0]  req_cs = '0;
  logic [63:0] ctrl_words = '0;
  logic        busy, rsp_valid, spi_sclk, spi_mosi, spi_miso;
  logic [31:0] rsp_data;
  logic [1:0]  spi_cs_n;

  always #2.5 clk = ~clk;

  sfl_read_seq #(.ADDR_W(32), .NUM_CS(NUM_CS), .HALF_DIV(1)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_cs(req_cs), .ctrl_words(ctrl_words),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_run = 0;
  int n_fail = 0;

  // flash model
  logic [7:0] mlog [0:127];
  int         mcnt = 0;
  int         mbit = 0;
  int         sclk_edges = 0;
  logic [7:0] msh = '0;
  logic [7:0] seed = '0;
  logic [1:0] cs_seen = '0;
  logic [7:0] cur_byte;

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 29 + 90) ^ seed;
  endfunction

  assign cur_byte = pat(mcnt);
  assign spi_miso = cur_byte[3'(7 - mbit)];

  always @(posedge spi_sclk) begin
    sclk_edges++;
    if (!(&spi_cs_n)) begin
      msh = {msh[6:0], spi_mosi};
      if (mbit == 7) begin
        if (mcnt < 128) mlog[mcnt] = msh;
        mcnt++;
        mbit = 0;
      end else begin
        mbit++;
      end
    end
  end

  always @(negedge clk) cs_seen = cs_seen | ~spi_cs_n;

  task automatic clear_model();
    mcnt = 0; mbit = 0; sclk_edges = 0; cs_seen = '0;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] opc, input logic [1:0] mode,
                                     input logic wide, input logic [2:0] d, input logic stop);
    logic [31:0] w;
    w = 32'hA500_0000;
    w[23:16] = opc; w[1:0] = mode; w[13] = wide;
    w[14] = d[2]; w[7:6] = d[1:0]; w[2] = stop;
    return w;
  endfunction

  task automatic wait_rsp(output logic [31:0] got, output int waited);
    waited = 0;
    while (!rsp_valid && waited < 5000) begin
      @(negedge clk); waited++;
    end
    got = rsp_data;
  endtask

  task automatic issue(input int cs, input logic [31:0] addr, input logic [1:0] sz);
    clear_model();
    req_cs = 1'(cs); req_addr = addr; req_bytes = sz; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // judge a finished read against the bench's own decode of the control word
  task automatic judge(input int cs, input logic [31:0] ctrl, input logic [31:0] addr,
                       input logic [1:0] sz, input logic [31:0] got, input int waited);
    int nab, nd, tot;
    bit ok;
    logic [31:0] exp;
    nab = ctrl[13] ? 4 : 3;
    nd  = int'({ctrl[14], ctrl[7:6]}) * 8;
    tot = 1 + nab + nd + int'(sz) + 1;
    chk(waited < 5000, "R9 response arrives", waited, 0);
    if (ctrl[2]) begin
      chk(cs_seen == 2'b00, "R7 chip select held off", cs_seen, 0);
      chk(sclk_edges == 8 * tot, "R7 sequence still clocked", sclk_edges, 8 * tot);
      return;
    end
    chk(mcnt == tot, "R4 total byte count", mcnt, tot);
    chk(mlog[0] == ctrl[23:16], "R2 R10 opcode first", mlog[0], ctrl[23:16]);
    ok = 1;
    for (int i = 0; i < nab; i++)
      if (mlog[1 + i] != addr[8 * (nab - 1 - i) +: 8]) ok = 0;
    chk(ok, "R3 address bytes", mlog[1], addr);
    ok = 1;
    for (int i = 0; i < nd; i++)
      if (mlog[1 + nab + i] != 8'hFF) ok = 0;
    chk(ok, "R4 dummy bytes 0xFF", nd, nd);
    ok = 1;
    exp = '0;
    for (int i = 0; i <= int'(sz); i++) begin
      if (mlog[1 + nab + nd + i] != 8'h00) ok = 0;
      exp[8 * i +: 8] = pat(1 + nab + nd + i);
    end
    chk(ok, "R5 data phase sends 0x00", 0, 0);
    chk(got == exp, "R5 response packing", got, exp);
    chk(cs_seen == (2'b01 << cs), "R8 chip select line", cs_seen, 2'b01 << cs);
  endtask

  task automatic do_read(input int cs, input logic [31:0] ctrl, input logic [31:0] addr,
                         input logic [1:0] sz, input logic [7:0] sd);
    logic [31:0] got;
    int waited;
    seed = sd;
    ctrl_words[cs * 32 +: 32] = ctrl;
    issue(cs, addr, sz);
    wait_rsp(got, waited);
    judge(cs, ctrl, addr, sz, got, waited);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] got, ctrl, a;
    int waited, idx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 2'b11, "R1 chip selects idle", spi_cs_n, 2'b11);
    chk(!spi_sclk && !busy && !rsp_valid, "R1 sclk busy rsp idle",
        {spi_sclk, busy, rsp_valid}, 0);

    // sweep: read/fast modes, address width, every dummy code, every length
    idx = 0;
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 8; d++)
          for (int s = 0; s < 4; s++) begin
            ctrl = mk(8'h0B ^ 8'(idx), 2'(m), 1'(w), 3'(d), 1'b0);
            a = {8'(idx), ~8'(idx), 8'h3C ^ 8'(idx * 3), 8'(idx * 7)};
            do_read(idx & 1, ctrl, a, 2'(s), 8'(idx * 13));
            idx++;
          end

    // R6 write and user modes: immediate zero response, bus untouched
    for (int m = 2; m < 4; m++) begin
      ctrl_words[31:0] = mk(8'h02, 2'(m), 1'b0, 3'd3, 1'b0);
      issue(0, 32'h0012_3456, 2'd3);
      wait_rsp(got, waited);
      chk(got == 32'h0, "R6 non-read data", got, 0);
      chk(waited <= 4, "R6 non-read latency", waited, 4);
      chk(cs_seen == 2'b00 && sclk_edges == 0, "R6 non-read bus quiet",
          {cs_seen, 8'(sclk_edges)}, 0);
      @(negedge clk);
    end

    // R7 chip-select suppression
    do_read(1, mk(8'h0B, 2'd1, 1'b1, 3'd1, 1'b1), 32'hCAFE_0001, 2'd1, 8'h11);
    do_read(0, mk(8'h03, 2'd0, 1'b0, 3'd0, 1'b1), 32'h0000_0100, 2'd0, 8'h22);

    // R9 back-to-back: request held high; response and next accept share a cycle
    ctrl = mk(8'h3B, 2'd1, 1'b1, 3'd2, 1'b0);
    ctrl_words[31:0] = ctrl;
    seed = 8'h77;
    clear_model();
    req_cs = 1'b0; req_addr = 32'h1234_5678; req_bytes = 2'd3; req_valid = 1'b1;
    @(negedge clk);
    chk(busy, "R9 accepted", busy, 1);
    repeat (20) @(negedge clk);
    req_addr = 32'hDEAD_BEEF;
    wait_rsp(got, waited);
    judge(0, ctrl, 32'h1234_5678, 2'd3, got, waited);
    clear_model();
    req_addr = 32'h0BAD_F00D; req_bytes = 2'd0;
    @(negedge clk);
    chk(busy, "R9 accept in response cycle", busy, 1);
    req_valid = 1'b0;
    wait_rsp(got, waited);
    judge(0, ctrl, 32'h0BAD_F00D, 2'd0, got, waited);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule